// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one PWM command into two gate enables for a half-bridge: one for the high-side switch and one for the low-side switch. It never lets the two overlap. It does not count a fixed dead time. After it drops one gate, it waits for feedback before it raises the other:

- Before the high side turns on, a comparator flag must report that the low-gate voltage has fallen below its threshold.
- Before the low side turns on, a flag must report that the phase node has fallen below its threshold.

All analog sensing arrives as logic flags that are already compared. Every delay is a count of clock cycles, derived from a clock-period parameter and a time in nanoseconds.

Around this core sit three protections:

- **Supply gate with hysteresis.** Both gates stay off until the supply-good rising flag is seen. They turn off again on the falling flag.
- **Holdoff timer on the mid-level PWM window.** A PWM input that stays in the middle band long enough shuts both gates down.
- **Low-side supervisor.** If the phase flag never falls, it forces the low side on after a refresh timeout so the bootstrap charge is kept. If the phase then stays high too long with the low side on, it latches a fault.

A two-bit mode output reports which of these conditions currently owns the gates.

Top module: `gate_seq_top`

## Requirements
- R1: After reset both gates are off and mode is 0 (supply off). The supply is considered good from the clock edge that samples `vcc_rise_ok`=1, and bad from the edge that samples `vcc_fall_low`=1. Between those events it keeps its last state. While the supply is bad, both gates are off and mode is 0.
- R2: When PWM goes high, the low gate turns off first. The high gate turns on only at the first clock edge that samples `lg_below`=1 while PWM is high. There is no timeout while waiting, and both gates stay off for as long as `lg_below` stays 0.
- R3: When PWM goes low, the high gate turns off first. The low gate turns on at the first later edge that samples `ph_below`=1.
- R4: If `ph_below` stays 0 after the high gate turns off, the low gate turns on anyway after REFRESH_CYC = ceil(REFRESH_NS/CLK_NS) cycles in the wait state (13 cycles by default).
- R5: While the low gate is on, if `ph_below` is sampled 0 on FAULT_CYC = ceil(FAULT_NS/CLK_NS) consecutive edges (100 by default), the low gate turns off and a fault latches with mode 2. The fault holds both gates off until PWM goes from not-high to high. One cycle fewer of high phase causes no fault.
- R6: When PWM has been in the mid window for HOLDOFF_CYC = ceil(HOLDOFF_NS/CLK_NS) consecutive edges (8 by default), both gates turn off and mode is 1. The shutdown clears at the first edge that samples PWM outside the window.
- R7: The two gate enables are never on in the same cycle. Whenever one gate turns on, the other was off in the previous cycle.
- R8: Mode encoding is 0 supply off, 1 window shutdown, 2 phase fault, 3 running, with priority in that order.
- R9: The `pwm_code` encoding is 00 low, 01 high, and 10 or 11 mid window. A mid interval shorter than the holdoff leaves the gates unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_code | input | 2 | Three-state PWM decode: 00 low, 01 high, 1x mid window |
| lg_below | input | 1 | Low-gate voltage is below its turn-off threshold |
| ph_below | input | 1 | Phase node is below its threshold |
| vcc_rise_ok | input | 1 | Supply is above its rising threshold |
| vcc_fall_low | input | 1 | Supply is below its falling threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| mode | output | 2 | Current mode, encoded as in R8 |

## Verification
The hardest case to reach is the exact boundary between a phase fault and no fault. The low side must first be on, which itself needs the feedback handshake, and the phase flag must then be held high for exactly FAULT_CYC-1 edges and then for exactly FAULT_CYC edges, with a low sample in between to clear the count. The bench drives the flags on falling edges and counts edges between changes. It also sweeps the cycle at which the phase flag falls, across and past the refresh timeout, and checks the arithmetic handover time for each value.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SHUT  = 2'd1,
    MODE_FAULT = 2'd2,
    MODE_RUN   = 2'd3
  } mode_e;

  localparam logic [1:0] PWM_LO = 2'b00;
  localparam logic [1:0] PWM_HI = 2'b01;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/gseq_supply.sv
module gseq_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ok,
  input  logic fall_low,
  output logic sup_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sup_ok <= 1'b0;
    else if (!sup_ok && rise_ok)
      sup_ok <= 1'b1;
    else if (sup_ok && fall_low)
      sup_ok <= 1'b0;
  end

  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && !fall_low) |=> sup_ok); // R1
  AST_SUPPLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok && !rise_ok) |=> !sup_ok); // R1
endmodule

// File: rtl/gseq_window.sv
module gseq_window #(
  parameter int HOLDOFF_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  output logic       shut
);
  localparam int CW = (HOLDOFF_CYC > 1) ? $clog2(HOLDOFF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

  logic          mid;
  logic [CW-1:0] cnt_q;

  assign mid = pwm_code[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shut  <= 1'b0;
    end else begin
      shut  <= mid && (shut || cnt_q == LAST);
      if (!mid)
        cnt_q <= '0;
      else if (cnt_q != LAST)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_SHUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !mid |=> !shut); // R6
endmodule

// File: rtl/gseq_core.sv
module gseq_core #(
  parameter int REFRESH_CYC = 13,
  parameter int FAULT_CYC   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_code,
  input  logic       lg_below,
  input  logic       ph_below,
  output logic       hs_q,
  output logic       ls_q,
  output logic       fault_q
);
  import gseq_pkg::*;

  localparam int MAXC = (REFRESH_CYC > FAULT_CYC) ? REFRESH_CYC : FAULT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] REF_LAST   = CW'(REFRESH_CYC - 1);
  localparam logic [CW-1:0] FAULT_LAST = CW'(FAULT_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LSOFF, S_HSON, S_HSOFF, S_LSON, S_FAULT
  } st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_hi;
  logic          hi, lo, rise;

  assign hi   = (pwm_code == PWM_HI);
  assign lo   = (pwm_code == PWM_LO);
  assign rise = hi && !prev_hi;

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    case (st_q)
      S_IDLE:  if (hi) st_d = S_LSOFF;
               else if (lo) st_d = S_HSOFF;
      S_LSOFF: if (lo) st_d = S_HSOFF;
               else if (hi && lg_below) st_d = S_HSON;
      S_HSON:  if (lo) st_d = S_HSOFF;
      S_HSOFF: begin
        if (hi) st_d = S_LSOFF;
        else if (ph_below || cnt_q == REF_LAST) st_d = S_LSON;
        else cnt_d = cnt_q + 1'b1;
      end
      S_LSON: begin
        if (hi) st_d = S_LSOFF;
        else if (!ph_below) begin
          if (cnt_q == FAULT_LAST) st_d = S_FAULT;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      S_FAULT: if (rise) st_d = S_LSOFF;
      default: st_d = S_IDLE;
    endcase
    if (!en) begin
      st_d  = S_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      prev_hi <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      prev_hi <= hi;
    end
  end

  assign hs_q    = (st_q == S_HSON);
  assign ls_q    = (st_q == S_LSON);
  assign fault_q = (st_q == S_FAULT);

  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && en && !rise) |=> fault_q); // R5
  AST_NO_LSOFF_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LSOFF && en && hi && !lg_below) |=> (st_q == S_LSOFF)); // R2
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top #(
  parameter int CLK_NS     = 20,
  parameter int REFRESH_NS = 250,
  parameter int FAULT_NS   = 2000,
  parameter int HOLDOFF_NS = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  input  logic       lg_below,
  input  logic       ph_below,
  input  logic       vcc_rise_ok,
  input  logic       vcc_fall_low,
  output logic       hs_en,
  output logic       ls_en,
  output logic [1:0] mode
);
  import gseq_pkg::*;

  localparam int REFRESH_CYC = ns_to_cyc(REFRESH_NS, CLK_NS);
  localparam int FAULT_CYC   = ns_to_cyc(FAULT_NS, CLK_NS);
  localparam int HOLDOFF_CYC = ns_to_cyc(HOLDOFF_NS, CLK_NS);

  logic sup_ok, shut, en;
  logic hs_q, ls_q, fault_q;
  mode_e mode_w;

  gseq_supply u_supply (
    .clk(clk), .rst_n(rst_n), .rise_ok(vcc_rise_ok),
    .fall_low(vcc_fall_low), .sup_ok(sup_ok)
  );

  gseq_window #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .shut(shut)
  );

  assign en = sup_ok && !shut;

  gseq_core #(.REFRESH_CYC(REFRESH_CYC), .FAULT_CYC(FAULT_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_code(pwm_code),
    .lg_below(lg_below), .ph_below(ph_below),
    .hs_q(hs_q), .ls_q(ls_q), .fault_q(fault_q)
  );

  assign hs_en = hs_q && en;
  assign ls_en = ls_q && en;

  always_comb begin
    if (!sup_ok)      mode_w = MODE_OFF;
    else if (shut)    mode_w = MODE_SHUT;
    else if (fault_q) mode_w = MODE_FAULT;
    else              mode_w = MODE_RUN;
  end
  assign mode = mode_w;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en)); // R7
  AST_HS_AFTER_LG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(lg_below) && !$past(ls_en))); // R2
  AST_LS_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en)); // R3
  AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!hs_en && !ls_en)); // R5
endmodule

// File: tb/gate_seq_top_bench.sv
module gate_seq_top_bench;
  localparam int CLK_NS  = 20;
  localparam int REF_C   = (250 + CLK_NS - 1) / CLK_NS;
  localparam int FAULT_C = (2000 + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_C  = (160 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwm_code = 2'b00;
  logic lg_below = 1'b0, ph_below = 1'b0;
  logic vcc_rise_ok = 1'b0, vcc_fall_low = 1'b0;
  logic hs_en, ls_en;
  logic [1:0] mode;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  logic prev_hs = 1'b0, prev_ls = 1'b0;

  always #10 clk = ~clk;

  gate_seq_top #(.CLK_NS(CLK_NS)) u_gate_seq_top (
    .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .lg_below(lg_below),
    .ph_below(ph_below), .vcc_rise_ok(vcc_rise_ok), .vcc_fall_low(vcc_fall_low),
    .hs_en(hs_en), .ls_en(ls_en), .mode(mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic gates(input string tag, input bit h, input bit l, input int m);
    chk(hs_en == h, {tag, " hs_en"}, hs_en, h);
    chk(ls_en == l, {tag, " ls_en"}, ls_en, l);
    chk(mode == m, {tag, " mode"}, mode, m);
  endtask

  // R7 monitor: no overlap, and a gate only rises after the other was off
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_en && ls_en) begin
        failures++; $display("FAIL R7 overlap actual=1 expected=0");
      end
      if ((hs_en && !prev_hs && prev_ls) || (ls_en && !prev_ls && prev_hs)) begin
        failures++; $display("FAIL R7 no gap actual=1 expected=0");
      end
    end
    prev_hs <= hs_en;
    prev_ls <= ls_en;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    gates("R8 reset", 0, 0, 0);
    rst_n = 1'b1;

    // R1: no supply, gates held off
    pwm_code = 2'b01; lg_below = 1'b1;
    tick(5);
    gates("R1 no supply", 0, 0, 0);
    vcc_rise_ok = 1'b1; tick(1); vcc_rise_ok = 1'b0;
    gates("R1 supply good", 0, 0, 3);
    tick(2);
    gates("R2 hs on", 1, 0, 3);

    // R3/R4 sweep of phase-fall delay across the refresh timeout
    for (int d = 1; d <= REF_C + 2; d++) begin
      int n;
      int expd;
      pwm_code = 2'b00; ph_below = 1'b0;
      n = 0;
      while (!ls_en && n < 60) begin
        @(posedge clk); n++; @(negedge clk);
        if (hs_en) chk(0, "R3 hs still on", 1, 0);
        if (n == d) ph_below = 1'b1;
      end
      expd = ((d < REF_C) ? d : REF_C) + 1;
      chk(n == expd, (d >= REF_C) ? "R4 refresh timeout" : "R3 phase handover", n, expd);
      pwm_code = 2'b01; lg_below = 1'b1;
      tick(2);
      gates("R2 return hs", 1, 0, 3);
    end

    // R2: waiting for low-gate flag has no timeout
    pwm_code = 2'b00; ph_below = 1'b1; tick(2);
    gates("R3 ls on", 0, 1, 3);
    lg_below = 1'b0; pwm_code = 2'b01;
    tick(60);
    gates("R2 wait lg", 0, 0, 3);
    lg_below = 1'b1; tick(1);
    gates("R2 lg seen", 1, 0, 3);

    // R5: phase-high fault boundary
    pwm_code = 2'b00; ph_below = 1'b1; tick(2);
    ph_below = 1'b0; tick(FAULT_C - 1);
    gates("R5 one short", 0, 1, 3);
    ph_below = 1'b1; tick(1);
    ph_below = 1'b0; tick(FAULT_C - 1);
    gates("R5 before fault", 0, 1, 3);
    tick(1);
    gates("R5 fault", 0, 0, 2);
    ph_below = 1'b1; tick(5);
    gates("R5 latched", 0, 0, 2);
    pwm_code = 2'b01; lg_below = 1'b1; tick(2);
    gates("R5 exit on rise", 1, 0, 3);

    // R6/R9: holdoff window for both mid codes
    for (int c = 2; c <= 3; c++) begin
      pwm_code = 2'(c); tick(HOLD_C - 1);
      gates("R9 mid short", 1, 0, 3);
      tick(1);
      gates("R6 shutdown", 0, 0, 1);
      tick(20);
      gates("R6 held", 0, 0, 1);
      pwm_code = 2'b01; tick(1);
      gates("R6 release", 0, 0, 3);
      tick(2);
      gates("R6 resume", 1, 0, 3);
    end

    // R9: short mid interval while low side on
    pwm_code = 2'b00; ph_below = 1'b1; tick(2);
    pwm_code = 2'b10; tick(HOLD_C - 1);
    gates("R9 ls held", 0, 1, 3);
    pwm_code = 2'b00; tick(1);
    gates("R9 back low", 0, 1, 3);

    // R1: hysteresis on falling flag
    vcc_fall_low = 1'b1; tick(1); vcc_fall_low = 1'b0;
    gates("R1 supply lost", 0, 0, 0);
    tick(10);
    gates("R1 stays off", 0, 0, 0);
    pwm_code = 2'b01; lg_below = 1'b1;
    vcc_rise_ok = 1'b1; tick(1); vcc_rise_ok = 1'b0;
    gates("R1 regain", 0, 0, 3);
    tick(2);
    gates("R1 running", 1, 0, 3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule